// File: doc/BRIEF.md
# Serial Port Status Flag and Interrupt Unit

This block keeps the eight status flags of a serial port and turns them into two interrupt requests. The transmit and receive datapaths report events to it as one-cycle pulses. Each pulse sets the matching flag, and the flag then holds until the CPU runs a two-step clear. The first step is a read of the status byte while the flag is 1, which arms the flag. The second step is an access to the data register: a write for the two transmit-side flags, or a read for the six receive-side flags. That access clears every armed flag on its side.

Each flag is a small state machine with three states. `FL_CLR` means the flag reads 0. `FL_SET` means it reads 1 but is not armed. `FL_ARMED` means it reads 1 and the next clearing access will clear it. The transitions are:

- set: `FL_CLR` → `FL_SET` on an event.
- arm: `FL_SET` → `FL_ARMED` on a status read.
- clear: `FL_ARMED` → `FL_CLR` on a clearing access with no event in that cycle.
- re-set: `FL_ARMED` → `FL_SET` on a clearing access that coincides with an event.

In every other case the state holds. The two interrupt outputs are combinational ORs of the flags, each flag gated by its own enable.

Top module: `uart_flag_ctrl`

## Requirements
- R1: The status byte is laid out, from bit 7 down to bit 0, as: transmitter empty, transmission complete, receive full, idle, overrun, noise, framing error, parity error. The event input uses the same bit positions. After a synchronous reset the status byte reads 8'hC0.
- R2: An event pulse on bit i makes status bit i read 1 from the next cycle on.
- R3: A status read while bits 7 or 6 are 1, followed later by a data-register write, clears those bits in the cycle after the write.
- R4: A status read while any of bits 5..0 are 1, followed later by a data-register read, clears those bits in the cycle after the read.
- R5: A clearing access does not clear a flag that was not armed. This holds when no status read happened since the flag was set, when the read came while the flag was 0, and when the read falls in the same cycle as the access.
- R6: A data-register read does not clear bits 7..6, and a data-register write does not clear bits 5..0. A flag stays armed across an access of the wrong kind.
- R7: If an event arrives in the same cycle as the clearing access of an armed flag, the flag stays 1 and is disarmed, so a further access alone does not clear it.
- R8: `tx_irq_o` equals (bit 7 AND `txe_ie_i`) OR (bit 6 AND `tc_ie_i`), within the same cycle.
- R9: `err_irq_o` is the OR of overrun, noise, framing error and parity error, each ANDed with its own enable (`ovr_ie_i`, `nf_ie_i`, `fe_ie_i`, `pe_ie_i`), within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 8 | Event pulses, one per flag, in status bit order |
| stat_rd_i | input | 1 | CPU reads the status byte |
| data_rd_i | input | 1 | CPU reads the data register |
| data_wr_i | input | 1 | CPU writes the data register |
| txe_ie_i | input | 1 | Interrupt enable for transmitter empty |
| tc_ie_i | input | 1 | Interrupt enable for transmission complete |
| ovr_ie_i | input | 1 | Interrupt enable for overrun |
| nf_ie_i | input | 1 | Interrupt enable for noise |
| fe_ie_i | input | 1 | Interrupt enable for framing error |
| pe_ie_i | input | 1 | Interrupt enable for parity error |
| status_o | output | 8 | Status byte |
| tx_irq_o | output | 1 | Transmitter interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
A new event and the clearing data-register access can land in the same cycle. The bench provokes this by arming the transmitter-empty flag and then driving a data write together with a transmitter-empty event. The flag must still read 1 after that cycle. A second write on its own must then leave the flag at 1, which shows the flag was disarmed. A status read in the same cycle as the clearing access is also driven, and it must not clear a flag that was set but not yet armed.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    localparam int FLAG_W = 8;

    localparam int B_TXE = 7;
    localparam int B_TC  = 6;
    localparam int B_RXF = 5;
    localparam int B_IDL = 4;
    localparam int B_OVR = 3;
    localparam int B_NF  = 2;
    localparam int B_FE  = 1;
    localparam int B_PE  = 0;

    // flags that reset to 1
    localparam logic [FLAG_W-1:0] RST_VAL = (1 << B_TXE) | (1 << B_TC);
    // flags cleared by a data write (the rest are cleared by a data read)
    localparam logic [FLAG_W-1:0] TX_SIDE = (1 << B_TXE) | (1 << B_TC);

    typedef enum logic [1:0] {
        FL_CLR   = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_st_t;

endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell
    import uart_flag_pkg::*;
#(
    parameter bit RESET_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic stat_rd_i,
    input  logic clr_acc_i,
    output logic flag_o
);

    localparam flag_st_t RST_ST = RESET_SET ? FL_SET : FL_CLR;

    flag_st_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_ST;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLR: begin
                // a read in the same cycle saw 0, so it does not arm
                if (evt_i) state_d = FL_SET;
            end
            FL_SET: begin
                if (stat_rd_i) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (clr_acc_i) begin
                    state_d = evt_i ? FL_SET : FL_CLR;
                end
            end
            default: state_d = RST_ST;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FL_SET) || (state_q == FL_ARMED);
    end

endmodule

// File: rtl/uart_flag_acc.sv
module uart_flag_acc
    import uart_flag_pkg::*;
#(
    parameter int                 N_FLAGS   = FLAG_W,
    parameter logic [N_FLAGS-1:0] WR_CLEARS = TX_SIDE
) (
    input  logic               data_rd_i,
    input  logic               data_wr_i,
    output logic [N_FLAGS-1:0] clr_acc_o
);

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_acc
        if (WR_CLEARS[i]) begin : g_wr
            assign clr_acc_o[i] = data_wr_i;
        end else begin : g_rd
            assign clr_acc_o[i] = data_rd_i;
        end
    end

endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
    import uart_flag_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              txe_ie_i,
    input  logic              tc_ie_i,
    input  logic              ovr_ie_i,
    input  logic              nf_ie_i,
    input  logic              fe_ie_i,
    input  logic              pe_ie_i,
    output logic              tx_irq_o,
    output logic              err_irq_o
);

    logic [FLAG_W-1:0] en_mask;

    always_comb begin
        en_mask        = '0;
        en_mask[B_TXE] = txe_ie_i;
        en_mask[B_TC]  = tc_ie_i;
        en_mask[B_OVR] = ovr_ie_i;
        en_mask[B_NF]  = nf_ie_i;
        en_mask[B_FE]  = fe_ie_i;
        en_mask[B_PE]  = pe_ie_i;
    end

    always_comb begin
        tx_irq_o  = |(flags_i & en_mask & TX_SIDE);
        err_irq_o = |(flags_i & en_mask & ~TX_SIDE);
    end

endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import uart_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt_i,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    input  logic              data_wr_i,
    input  logic              txe_ie_i,
    input  logic              tc_ie_i,
    input  logic              ovr_ie_i,
    input  logic              nf_ie_i,
    input  logic              fe_ie_i,
    input  logic              pe_ie_i,
    output logic [FLAG_W-1:0] status_o,
    output logic              tx_irq_o,
    output logic              err_irq_o
);

    logic [FLAG_W-1:0] clr_acc;
    logic [FLAG_W-1:0] flags;

    uart_flag_acc #(
        .N_FLAGS   (FLAG_W),
        .WR_CLEARS (TX_SIDE)
    ) u_acc (
        .data_rd_i (data_rd_i),
        .data_wr_i (data_wr_i),
        .clr_acc_o (clr_acc)
    );

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        uart_flag_cell #(
            .RESET_SET (RST_VAL[i])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[i]),
            .stat_rd_i (stat_rd_i),
            .clr_acc_i (clr_acc[i]),
            .flag_o    (flags[i])
        );
    end

    uart_flag_irq u_irq (
        .flags_i   (flags),
        .txe_ie_i  (txe_ie_i),
        .tc_ie_i   (tc_ie_i),
        .ovr_ie_i  (ovr_ie_i),
        .nf_ie_i   (nf_ie_i),
        .fe_ie_i   (fe_ie_i),
        .pe_ie_i   (pe_ie_i),
        .tx_irq_o  (tx_irq_o),
        .err_irq_o (err_irq_o)
    );

    assign status_o = flags;

endmodule

// File: rtl/uart_flag_chk.sv
module uart_flag_chk
    import uart_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FLAG_W-1:0] evt_i,
    input logic              data_rd_i,
    input logic              data_wr_i,
    input logic              txe_ie_i,
    input logic              tc_ie_i,
    input logic              ovr_ie_i,
    input logic              nf_ie_i,
    input logic              fe_ie_i,
    input logic              pe_ie_i,
    input logic [FLAG_W-1:0] status_o,
    input logic              tx_irq_o,
    input logic              err_irq_o
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_q) |-> (status_o == RST_VAL));

    // R2
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R3
    tx_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_o) & ~status_o & TX_SIDE)) |-> $past(data_wr_i));

    // R4
    rx_fall_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_o) & ~status_o & ~TX_SIDE)) |-> $past(data_rd_i));

    // R7
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && evt_i[B_TXE]) |=> status_o[B_TXE]);

    // R8
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq_o == ((status_o[B_TXE] && txe_ie_i) || (status_o[B_TC] && tc_ie_i)));

    // R9
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o == ((status_o[B_OVR] && ovr_ie_i) || (status_o[B_NF] && nf_ie_i) ||
                      (status_o[B_FE] && fe_ie_i) || (status_o[B_PE] && pe_ie_i)));

endmodule

bind uart_flag_ctrl uart_flag_chk i_chk (.*);

// File: tb/test_uart_flag_ctrl.sv
module test_uart_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt = 8'h00;
    logic       rs = 1'b0, rd = 1'b0, wd = 1'b0;
    logic       txe_ie = 1'b0, tc_ie = 1'b0;
    logic [3:0] eie = 4'h0;  // [3]=overrun [2]=noise [1]=framing [0]=parity
    logic [7:0] status;
    logic       tx_irq, err_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    uart_flag_ctrl i_uart_flag_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .stat_rd_i (rs),
        .data_rd_i (rd),
        .data_wr_i (wd),
        .txe_ie_i  (txe_ie),
        .tc_ie_i   (tc_ie),
        .ovr_ie_i  (eie[3]),
        .nf_ie_i   (eie[2]),
        .fe_ie_i   (eie[1]),
        .pe_ie_i   (eie[0]),
        .status_o  (status),
        .tx_irq_o  (tx_irq),
        .err_irq_o (err_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock cycle of stimulus; outputs are stable when it returns
    task automatic cyc(input logic [7:0] e, input logic s, input logic r, input logic w);
        evt = e; rs = s; rd = r; wd = w;
        @(posedge clk);
        #2;
        evt = 8'h00; rs = 1'b0; rd = 1'b0; wd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] acc;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 status", status, 8'hC0);
        check("R1 tx_irq", {7'd0, tx_irq}, 8'd0);
        check("R1 err_irq", {7'd0, err_irq}, 8'd0);

        // R8 sweep with both transmit flags set
        for (int k = 0; k < 4; k++) begin
            txe_ie = k[1]; tc_ie = k[0];
            #1;
            check("R8 sweep", {7'd0, tx_irq}, {7'd0, (k != 0)});
        end

        // R3 clear both transmit flags
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        check("R3 read alone", status, 8'hC0);
        cyc(8'h00, 1'b0, 1'b0, 1'b1);
        check("R3 cleared", status, 8'h00);
        check("R8 flags low", {7'd0, tx_irq}, 8'd0);

        // R8 transmission complete alone
        cyc(8'h40, 1'b0, 1'b0, 1'b0);
        txe_ie = 1'b1; tc_ie = 1'b0; #1;
        check("R8 tc masked", {7'd0, tx_irq}, 8'd0);
        txe_ie = 1'b0; tc_ie = 1'b1; #1;
        check("R8 tc enabled", {7'd0, tx_irq}, 8'd1);
        tc_ie = 1'b0;

        // R2 set each flag in turn
        acc = 8'h40;
        for (int i = 0; i < 8; i++) begin
            cyc(8'(1 << i), 1'b0, 1'b0, 1'b0);
            acc = acc | 8'(1 << i);
            check("R2 set", status, acc);
        end

        // R9 full enable sweep with every error flag set
        for (int m = 0; m < 16; m++) begin
            eie = 4'(m); #1;
            check("R9 all set", {7'd0, err_irq}, {7'd0, (m != 0)});
        end
        eie = 4'h0;

        // R3 / R4 bulk clear
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 1'b1);
        check("R3 bulk", status, 8'h3F);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        check("R4 bulk", status, 8'h00);

        // R9 per-flag masking, R4 per-flag clear
        for (int j = 0; j < 4; j++) begin
            cyc(8'(1 << j), 1'b0, 1'b0, 1'b0);
            for (int m = 0; m < 16; m++) begin
                eie = 4'(m); #1;
                check("R9 single", {7'd0, err_irq}, {7'd0, m[j]});
            end
            eie = 4'h0;
            cyc(8'h00, 1'b1, 1'b0, 1'b0);
            cyc(8'h00, 1'b0, 1'b1, 1'b0);
            check("R4 single", status, 8'h00);
        end

        // R5 access with no prior read
        cyc(8'h10, 1'b0, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        check("R5 no read", status, 8'h10);
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        check("R4 idle", status, 8'h00);
        // R5 read while flag was 0 does not arm
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        cyc(8'h10, 1'b0, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        check("R5 read at zero", status, 8'h10);

        // R6 wrong access kind keeps rx flag armed
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 1'b1);
        check("R6 write on rx", status, 8'h10);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        check("R6 still armed", status, 8'h00);

        // R6 data read does not clear transmit flag
        cyc(8'h80, 1'b0, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        check("R6 read on tx", status, 8'h80);
        txe_ie = 1'b1; #1;
        check("R8 txe enabled", {7'd0, tx_irq}, 8'd1);
        txe_ie = 1'b0;
        cyc(8'h00, 1'b0, 1'b0, 1'b1);
        check("R3 after wrong kind", status, 8'h00);

        // R7 event with the clearing write
        cyc(8'h80, 1'b0, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        cyc(8'h80, 1'b0, 1'b0, 1'b1);
        check("R7 stays set", status, 8'h80);
        cyc(8'h00, 1'b0, 1'b0, 1'b1);
        check("R7 disarmed", status, 8'h80);
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 1'b1);
        check("R3 rearmed", status, 8'h00);

        // R5 read and access in the same cycle
        cyc(8'h01, 1'b0, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b1, 1'b0);
        check("R5 same cycle", status, 8'h01);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        check("R4 after same cycle", status, 8'h00);

        finish_run();
    end

endmodule